// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

An eight-pin general-purpose I/O port controller with three registers on a simple register bus: an output latch, a direction mask and a pull-up mask. For each pin the block drives an output enable, an output value and a pull-up enable towards the pad. It samples the pad level through a two-flop synchroniser. Reads of the data register return that sampled level. When the bus marks the access as part of a read-modify-write sequence, the read returns the output latch instead, so that the write-back cannot copy pin levels into the latch.

Two conditions override the pin controls. A stop condition with the high-impedance option selected removes all drive and all pull-ups. A pin that the converter has claimed as an analog input (converter enabled and the pin's channel selected) loses drive and pull-up, its digital input reads as 0, and it cannot raise an interrupt. The four low pins also feed external interrupt lines, each one gated by its own enable. Each pin has a flag that reports an analog pin whose direction bit still says output.

The register bus is a control path with one access per strobe and no back-pressure, so it has no valid/ready handshake. Every access completes in one clock. Read data is registered and appears on the cycle after the read strobe, then holds until the next read.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset the output latch, direction and pull-up registers are 0, so pad_oe, pad_out, pad_pu and bus_rdata are all 0.
- R2: A write to address 0 loads the output latch, which appears on pad_out after the write edge. pad_oe[n] follows bit n of the direction register (address 1, 1 = output) unless it is overridden.
- R3: A normal read of address 0 returns the pad level delayed by a two-flop synchroniser. A pad change before edge k is visible at the synchroniser output after edge k+1.
- R4: A read of address 0 with bus_rmw=1 returns the output latch, not the pin level.
- R5: The pull-up register at address 2 is readable and writable, and pad_pu[n] follows its bit n unless it is overridden.
- R6: The direction register at address 1 reads back the value last written.
- R7: When stop_mode=1 and stop_hiz=1, pad_oe and pad_pu are all 0 and the registers are unchanged. With stop_hiz=0, stop_mode has no effect on the pins.
- R8: When adc_en=1 and adc_sel[n]=1, ana_route[n]=1, pad_oe[n]=0 and pad_pu[n]=0, and bit n of a normal data read returns 0.
- R9: For each pin n from 0 to 3, ext_irq[n] equals the synchronised level of pin n ANDed with ext_irq_en[n], and it is forced to 0 while pin n is routed to the analog input.
- R10: ana_conflict[n] is 1 exactly when pin n is routed to the analog input and its direction bit is 1.
- R11: Address 3 reads as 0 and ignores writes. bus_rdata changes only on the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 data, 1 direction, 2 pull-up, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rmw | input | 1 | Read belongs to a read-modify-write sequence |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Output latch value |
| pad_oe | output | 8 | Per-pin output drive enable |
| pad_pu | output | 8 | Per-pin pull-up enable |
| stop_mode | input | 1 | Low-power stop active |
| stop_hiz | input | 1 | Release pins to high impedance during stop |
| adc_en | input | 1 | Converter enable |
| adc_sel | input | 8 | Per-pin analog channel select |
| ana_route | output | 8 | Pin routed to the analog input |
| ana_conflict | output | 8 | Analog pin with its direction set to output |
| ext_irq_en | input | 4 | External interrupt enables, pins 3..0 |
| ext_irq | output | 4 | Gated interrupt levels, pins 3..0 |

## Verification
A data read and a data write can fall in the same cycle as a pad change, a change of stop mode or a change of analog selection. The read result then depends on whether bus_rmw was set and on which pins were analog at the read edge. The bench provokes these cases with long runs of random strobes, pad levels, overrides and enables, and compares every port on every cycle against a behavioural model that captures read data before it applies writes. Directed steps pin down the rmw read against the pin read, the mask applied to analog pins and the synchroniser latency.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_PULL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      pull_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      pull_q  <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(addr))
        REG_DATA: latch_q <= wdata;
        REG_DIR:  dir_q   <= wdata;
        REG_PULL: pull_q  <= wdata;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_gate.sv
module gpio_pin_gate #(
  parameter int W    = 8,
  parameter int NIRQ = 4
) (
  input  logic [W-1:0]    latch_q,
  input  logic [W-1:0]    dir_q,
  input  logic [W-1:0]    pull_q,
  input  logic [W-1:0]    pin_sync,
  input  logic            stop_mode,
  input  logic            stop_hiz,
  input  logic            adc_en,
  input  logic [W-1:0]    adc_sel,
  input  logic [NIRQ-1:0] irq_en,
  output logic [W-1:0]    oe,
  output logic [W-1:0]    out,
  output logic [W-1:0]    pu,
  output logic [W-1:0]    ana,
  output logic [W-1:0]    conflict,
  output logic [W-1:0]    pin_dig,
  output logic [NIRQ-1:0] irq
);
  logic release_pins;
  assign release_pins = stop_mode & stop_hiz;

  for (genvar n = 0; n < W; n++) begin : g_pin
    logic is_ana;
    assign is_ana      = adc_en & adc_sel[n];
    assign ana[n]      = is_ana;
    assign oe[n]       = dir_q[n] & ~release_pins & ~is_ana;
    assign pu[n]       = pull_q[n] & ~release_pins & ~is_ana;
    assign out[n]      = latch_q[n];
    assign conflict[n] = is_ana & dir_q[n];
    assign pin_dig[n]  = pin_sync[n] & ~is_ana;
  end

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    assign irq[i] = pin_dig[i] & irq_en[i];
  end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
#(
  parameter int W           = 8,
  parameter int NIRQ        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_rmw,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_pu,
  input  logic              stop_mode,
  input  logic              stop_hiz,
  input  logic              adc_en,
  input  logic [W-1:0]      adc_sel,
  output logic [W-1:0]      ana_route,
  output logic [W-1:0]      ana_conflict,
  input  logic [NIRQ-1:0]   ext_irq_en,
  output logic [NIRQ-1:0]   ext_irq
);
  logic [W-1:0] latch_q, dir_q, pull_q, pin_sync, pin_dig, rd_mux;
  logic         wr_en, rd_en;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpio_pin_gate #(.W(W), .NIRQ(NIRQ)) u_gate (
    .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q), .pin_sync(pin_sync),
    .stop_mode(stop_mode), .stop_hiz(stop_hiz), .adc_en(adc_en),
    .adc_sel(adc_sel), .irq_en(ext_irq_en), .oe(pad_oe), .out(pad_out),
    .pu(pad_pu), .ana(ana_route), .conflict(ana_conflict),
    .pin_dig(pin_dig), .irq(ext_irq)
  );

  always_comb begin
    case (reg_sel_e'(bus_addr))
      REG_DATA: rd_mux = bus_rmw ? latch_q : pin_dig;
      REG_DIR:  rd_mux = dir_q;
      REG_PULL: rd_mux = pull_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W    = 8,
  parameter int NIRQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [1:0]      bus_addr,
  input logic [W-1:0]    bus_wdata,
  input logic            bus_rmw,
  input logic [W-1:0]    bus_rdata,
  input logic [W-1:0]    pad_out,
  input logic [W-1:0]    pad_oe,
  input logic [W-1:0]    pad_pu,
  input logic            stop_mode,
  input logic            stop_hiz,
  input logic [W-1:0]    ana_route,
  input logic [W-1:0]    ana_conflict,
  input logic [NIRQ-1:0] ext_irq_en,
  input logic [NIRQ-1:0] ext_irq
);
  // R7
  hiz_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && stop_hiz) |-> (pad_oe == '0 && pad_pu == '0));
  // R8
  analog_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_pu) & ana_route) == '0);
  // R4
  rmw_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 2'd0 && bus_rmw) |=> bus_rdata == $past(pad_out));
  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd0) |=> pad_out == $past(bus_wdata));
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
  // R11
  unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 2'd3) |=> bus_rdata == '0);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_irq & ~(ext_irq_en & ~ana_route[NIRQ-1:0])) == '0);
  // R10
  conflict_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ana_conflict & ~ana_route) == '0);
endmodule

bind gpio_port_ctl gpio_port_chk #(.W(W), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rmw(bus_rmw),
  .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_pu(pad_pu), .stop_mode(stop_mode), .stop_hiz(stop_hiz),
  .ana_route(ana_route), .ana_conflict(ana_conflict),
  .ext_irq_en(ext_irq_en), .ext_irq(ext_irq)
);

// File: tb/sim_gpio_port_ctl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rmw = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, pad_in = '0, adc_sel = '0;
  logic       stop_mode = 1'b0, stop_hiz = 1'b0, adc_en = 1'b0;
  logic [3:0] ext_irq_en = '0;
  logic [7:0] bus_rdata, pad_out, pad_oe, pad_pu, ana_route, ana_conflict;
  logic [3:0] ext_irq;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rmw(bus_rmw),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .stop_mode(stop_mode),
    .stop_hiz(stop_hiz), .adc_en(adc_en), .adc_sel(adc_sel),
    .ana_route(ana_route), .ana_conflict(ana_conflict),
    .ext_irq_en(ext_irq_en), .ext_irq(ext_irq)
  );

  // Behavioural reference model
  logic [7:0] m_lat = 0, m_dir = 0, m_pu = 0, m_rd = 0;
  logic [7:0] m_pins [$];
  initial begin m_pins.push_back(8'h00); m_pins.push_back(8'h00); end

  function automatic logic [7:0] m_ana();
    return adc_en ? adc_sel : 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat = 0; m_dir = 0; m_pu = 0; m_rd = 0;
      m_pins = {8'h00, 8'h00};
    end else begin
      if (bus_sel && !bus_wr) begin
        if (bus_addr == 0)      m_rd = bus_rmw ? m_lat : (m_pins[0] & ~m_ana());
        else if (bus_addr == 1) m_rd = m_dir;
        else if (bus_addr == 2) m_rd = m_pu;
        else                    m_rd = 0;
      end
      if (bus_sel && bus_wr) begin
        if (bus_addr == 0) m_lat = bus_wdata;
        if (bus_addr == 1) m_dir = bus_wdata;
        if (bus_addr == 2) m_pu = bus_wdata;
      end
      void'(m_pins.pop_front());
      m_pins.push_back(pad_in);
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic hz;
      logic [7:0] a, e_irq;
      hz = stop_mode && stop_hiz;
      a = m_ana();
      e_irq = {4'h0, m_pins[0][3:0] & ext_irq_en & ~a[3:0]};
      chk("R2 model pad_out", pad_out, m_lat);
      chk("R7 model pad_oe", pad_oe, hz ? 8'h00 : (m_dir & ~a));
      chk("R5 model pad_pu", pad_pu, hz ? 8'h00 : (m_pu & ~a));
      chk("R8 model ana_route", ana_route, a);
      chk("R10 model ana_conflict", ana_conflict, a & m_dir);
      chk("R9 model ext_irq", {4'h0, ext_irq}, e_irq);
      chk("R3 model bus_rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_rmw = 0;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic rmw, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_rmw = rmw;
    @(negedge clk);
    bus_sel = 0; bus_rmw = 0;
    #2 v = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk); #2;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 pad_pu", pad_pu, 8'h00);
    chk("R1 bus_rdata", bus_rdata, 8'h00);
    // R2 latch and direction
    wr(1, 8'h0F); wr(0, 8'hA5); #2;
    chk("R2 pad_out", pad_out, 8'hA5);
    chk("R2 pad_oe", pad_oe, 8'h0F);
    rd(1, 0, v); chk("R6 dir readback", v, 8'h0F);
    // R3 synchroniser latency and pin read
    ext_irq_en = 4'hF;
    @(negedge clk); pad_in = 8'h3D;
    settle(); chk("R3 ext_irq after one edge", {4'h0, ext_irq}, 8'h00);
    settle(); chk("R9 ext_irq after two edges", {4'h0, ext_irq}, 8'h0D);
    rd(0, 0, v); chk("R3 pin read", v, 8'h3D);
    // R4 rmw read
    rd(0, 1, v); chk("R4 rmw read", v, 8'hA5);
    // R5 pull-up
    wr(2, 8'hF0); #2;
    chk("R5 pad_pu", pad_pu, 8'hF0);
    rd(2, 0, v); chk("R5 pull readback", v, 8'hF0);
    // R7 stop mode
    stop_mode = 1; settle();
    chk("R7 stop without hiz oe", pad_oe, 8'h0F);
    stop_hiz = 1; settle();
    chk("R7 hiz oe", pad_oe, 8'h00);
    chk("R7 hiz pu", pad_pu, 8'h00);
    chk("R7 hiz latch kept", pad_out, 8'hA5);
    stop_mode = 0; stop_hiz = 0; settle();
    chk("R7 released", pad_oe, 8'h0F);
    // R8 analog routing
    adc_en = 1; adc_sel = 8'h31; settle();
    chk("R8 ana_route", ana_route, 8'h31);
    chk("R8 pad_oe", pad_oe, 8'h0E);
    chk("R8 pad_pu", pad_pu, 8'hC0);
    chk("R10 conflict", ana_conflict, 8'h01);
    chk("R9 irq masked on analog pin", {4'h0, ext_irq}, 8'h0C);
    rd(0, 0, v); chk("R8 analog bits read 0", v, 8'h0C);
    adc_en = 0; settle();
    chk("R8 adc_en off", ana_route, 8'h00);
    // R11 unused address
    wr(3, 8'hFF);
    rd(3, 0, v); chk("R11 unused reads 0", v, 8'h00);
    rd(1, 0, v); chk("R11 dir untouched", v, 8'h0F);
    repeat (3) @(negedge clk);
    #2 chk("R11 rdata holds", bus_rdata, 8'h0F);
    // Random phase, judged by the per-clock model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      bus_sel = 1'($urandom_range(0, 1));
      bus_wr = 1'($urandom_range(0, 1));
      bus_addr = 2'($urandom_range(0, 3));
      bus_wdata = 8'($urandom);
      bus_rmw = 1'($urandom_range(0, 1));
      pad_in = 8'($urandom);
      stop_mode = ($urandom_range(0, 7) == 0);
      stop_hiz = 1'($urandom_range(0, 1));
      adc_en = ($urandom_range(0, 3) == 0);
      adc_sel = 8'($urandom);
      ext_irq_en = 4'($urandom);
    end
    @(negedge clk);
    bus_sel = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule